// File: doc/BRIEF.md
# Direct-Sequence Bit-Group Chip Spreader

The spreader turns a stream of packet bytes into a serial stream of chips for a direct-sequence spread-spectrum transmitter. Each byte is cut into bit groups of 2 or 4 bits. Each group is replaced by a chip sequence of 8 or 16 chips, and the chips go out one per chip-clock enable. The chip clock runs at the spreading factor (chips per group divided by bits per group) times the bit clock, so a packet takes the same time on air with or without spreading.

No code table is stored. Every chip sequence is built on the fly from a single base word. The low bits of the group pick a rotation of the base. The top bit of the group either inverts all chips or, in OQPSK mode, flips every second chip (conjugation).

A start pulse opens a frame. The frame begins with a preamble of plain base sequences. After that, payload bytes are taken through a valid/ready handshake. The byte handshake completes only on the enable that sends the last chip of the preamble or of the previous byte, so the chip stream has no gaps. A frame ends at the first boundary where no byte is offered. The configuration inputs may change only while no frame is open.

Top module: `dsss_spreader`

## Requirements
- R1: With code length L (8 or 16) and B bits per group (2 or 4), let r be the group value without its top bit, and let step = L / 2^(B-1). Chip k of the sequence for that group equals chip (k + r*step) mod L of the base. Chip k of the base is bit k of `cfg_base`, and only the low 8 bits are used when L is 8.
- R2: When the top bit of the group is 1 and `cfg_oqpsk` is 0, every chip of the rotated base is inverted.
- R3: When the top bit of the group is 1 and `cfg_oqpsk` is 1, the chips at even positions (k = 0, 2, 4, ...) of the rotated base are inverted, and the odd positions are unchanged.
- R4: With base 0xB2, L = 8 and B = 2, group values 0, 1, 2 and 3 send the sequences 0xB2, 0x2B, 0x4D and 0xD4, taking bit 0 first. Byte 0xE4 sent low group first therefore gives the 32-chip word 0xD44D2BB2, first chip at bit 0.
- R5: Chips of a sequence leave chip 0 first. A chip is sent on each cycle with `chip_en` high while `chip_valid` is high. `chip_out` holds its value on cycles without an enable.
- R6: With `cfg_msb_first` = 0, a byte's groups are sent from bits [B-1:0] upward. With `cfg_msb_first` = 1, they are sent from bits [7:8-B] downward. The bits inside a group keep their order in both cases.
- R7: After a start, the base sequence is sent floor(`cfg_pre_bits` / B) times, with no inversion, before any payload. When that count is 0, the frame goes straight to payload.
- R8: When a frame is already sending, `in_ready` is high only on the enable cycle of the last chip of the preamble or of the current byte. A byte accepted there starts its first chip on the next cycle, with no gap. In a frame that has opened but has nothing queued, `in_ready` stays high.
- R9: If no byte is accepted at a boundary, the frame ends. From then on `chip_valid` and `in_ready` stay low until the next start.
- R10: A start pulse while a frame is open is ignored.
- R11: After reset, `chip_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip-clock enable; one chip leaves per high cycle |
| start | input | 1 | Opens a frame when none is open |
| cfg_base | input | 16 | Base chip sequence, bit k = chip k |
| cfg_len16 | input | 1 | 1: 16-chip codes, 0: 8-chip codes |
| cfg_bits4 | input | 1 | 1: 4 bits per group, 0: 2 bits per group |
| cfg_msb_first | input | 1 | Take a byte's groups from its high end first |
| cfg_oqpsk | input | 1 | Use conjugation instead of inversion |
| cfg_pre_bits | input | PRE_W | Preamble length in bits |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Byte taken on this cycle when in_valid is high |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | A chip is being presented |

## Verification
A wrong rotation index or a wrong flip mask corrupts `chip_out` within the first sequence of the affected group value, so it shows up no more than 16 enables after that group is sent. A miscounted chip or group position does two things. It moves the `in_ready` pulse away from the cycle the reference queue predicts, and it leaves `chip_valid` high or low against an empty or full queue. Either symptom appears at the next byte boundary. The bench compares valid, ready and each chip with a behavioural chip queue on every clock. This catches a slip in the preamble count or in frame termination on the exact cycle it happens.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 16;
  localparam int CIDX_W = $clog2(CODE_W);

  typedef logic [CODE_W-1:0] code_t;

  // Chip sequence for one group value: rotate base right, then flip chips.
  function automatic code_t build_code(input code_t base, input logic len16,
                                       input logic bits4, input logic oqpsk,
                                       input logic [3:0] grp);
    logic [4:0]  step;
    logic [2:0]  idx;
    logic [4:0]  sh;
    logic        top;
    logic [31:0] dbl16;
    logic [15:0] dbl8;
    code_t       r;
    code_t       mask;
    step  = len16 ? (bits4 ? 5'd2 : 5'd8) : (bits4 ? 5'd1 : 5'd4);
    idx   = bits4 ? grp[2:0] : {2'b00, grp[0]};
    top   = bits4 ? grp[3] : grp[1];
    sh    = 5'(5'(idx) * step);
    dbl16 = {base, base} >> sh;
    dbl8  = {base[7:0], base[7:0]} >> sh;
    r     = len16 ? dbl16[15:0] : {8'h00, dbl8[7:0]};
    mask  = oqpsk ? 16'h5555 : 16'hFFFF;
    if (!len16) mask = {8'h00, mask[7:0]};
    return top ? (r ^ mask) : r;
  endfunction

  // Group value number gi of a byte, in sending order.
  function automatic logic [3:0] take_group(input logic [BYTE_W-1:0] b,
                                            input logic bits4,
                                            input logic msb_first,
                                            input logic [1:0] gi);
    logic [1:0] sel;
    if (bits4) begin
      return (gi[0] ^ msb_first) ? b[7:4] : b[3:0];
    end
    sel = msb_first ? ~gi : gi;
    return {2'b00, b[{sel, 1'b0} +: 2]};
  endfunction
endpackage

// File: rtl/dsss_code_gen.sv
module dsss_code_gen
  import dsss_pkg::*;
(
  input  code_t      base,
  input  logic       len16,
  input  logic       bits4,
  input  logic       oqpsk,
  input  logic [3:0] grp,
  output code_t      code
);
  assign code = build_code(base, len16, bits4, oqpsk, grp);
endmodule

// File: rtl/dsss_group_sel.sv
module dsss_group_sel
  import dsss_pkg::*;
(
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              bits4,
  input  logic              msb_first,
  input  logic [1:0]        gi,
  output logic [3:0]        grp
);
  assign grp = take_group(data_byte, bits4, msb_first, gi);
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             start,
  input  logic [15:0]      cfg_base,
  input  logic             cfg_len16,
  input  logic             cfg_bits4,
  input  logic             cfg_msb_first,
  input  logic             cfg_oqpsk,
  input  logic [PRE_W-1:0] cfg_pre_bits,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             chip_out,
  output logic             chip_valid
);
  logic              armed;
  logic              pre_active;
  logic              have;
  logic [PRE_W-1:0]  pre_left;
  logic [BYTE_W-1:0] byte_q;
  logic [1:0]        grp_idx;
  logic [CIDX_W-1:0] chip_idx;

  // Named internal events.
  logic              chip_last;
  logic              grp_last;
  logic              unit_end;
  logic              accept;
  logic              start_ok;
  logic [PRE_W-1:0]  pre_count;
  logic [3:0]        byte_grp;
  logic [3:0]        cur_grp;
  code_t             code_word;

  assign chip_last  = chip_idx == (cfg_len16 ? CIDX_W'(CODE_W - 1) : CIDX_W'(CODE_W / 2 - 1));
  assign grp_last   = cfg_bits4 ? (grp_idx == 2'd1) : (grp_idx == 2'd3);
  assign chip_valid = pre_active | have;
  assign unit_end   = chip_en & chip_valid & chip_last &
                      (pre_active ? (pre_left == PRE_W'(1)) : grp_last);
  assign in_ready   = unit_end | (armed & ~chip_valid);
  assign accept     = in_valid & in_ready;
  assign start_ok   = start & ~armed;
  assign pre_count  = cfg_bits4 ? (cfg_pre_bits >> 2) : (cfg_pre_bits >> 1);
  assign cur_grp    = pre_active ? 4'd0 : byte_grp;
  assign chip_out   = chip_valid & code_word[chip_idx];

  dsss_group_sel u_grp (
    .data_byte (byte_q),
    .bits4     (cfg_bits4),
    .msb_first (cfg_msb_first),
    .gi        (grp_idx),
    .grp       (byte_grp)
  );

  dsss_code_gen u_code (
    .base  (cfg_base),
    .len16 (cfg_len16),
    .bits4 (cfg_bits4),
    .oqpsk (cfg_oqpsk),
    .grp   (cur_grp),
    .code  (code_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      pre_active <= 1'b0;
      have       <= 1'b0;
      pre_left   <= '0;
      byte_q     <= '0;
      grp_idx    <= '0;
      chip_idx   <= '0;
    end else if (start_ok) begin
      armed      <= 1'b1;
      pre_left   <= pre_count;
      pre_active <= pre_count != '0;
      have       <= 1'b0;
      chip_idx   <= '0;
      grp_idx    <= '0;
    end else begin
      if (chip_en && chip_valid) begin
        if (chip_last) begin
          chip_idx <= '0;
          if (pre_active) begin
            pre_left <= pre_left - PRE_W'(1);
            if (pre_left == PRE_W'(1)) pre_active <= 1'b0;
          end else begin
            grp_idx <= grp_last ? 2'd0 : grp_idx + 2'd1;
            if (grp_last) have <= 1'b0;
          end
        end else begin
          chip_idx <= chip_idx + CIDX_W'(1);
        end
      end
      if (unit_end && !accept) armed <= 1'b0;
      if (accept) begin
        byte_q   <= in_data;
        have     <= 1'b1;
        grp_idx  <= '0;
        chip_idx <= '0;
      end
    end
  end

  AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && chip_valid) |-> (chip_en && chip_last)); // R8
  AST_GAPLESS_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chip_valid) |=> (chip_valid && chip_idx == '0)); // R8
  AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && !chip_en) |=> (chip_valid && $stable(chip_out))); // R5
  AST_QUIET_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!chip_valid && !in_ready)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && start && !chip_en) |=> $stable(pre_left)); // R10
  AST_PREAMBLE_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_active |-> (code_word == (cfg_len16 ? cfg_base : {8'h00, cfg_base[7:0]}))); // R7
endmodule

// File: tb/sim_dsss_spreader.sv
module sim_dsss_spreader;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b0;
  logic       start = 1'b0;
  logic [15:0] cfg_base = 16'h00B2;
  logic       cfg_len16 = 1'b0;
  logic       cfg_bits4 = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_oqpsk = 1'b0;
  logic [7:0] cfg_pre_bits = 8'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       chip_out;
  logic       chip_valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dsss_spreader #(.PRE_W(8)) u0 (
    .clk, .rst_n, .chip_en, .start, .cfg_base, .cfg_len16, .cfg_bits4,
    .cfg_msb_first, .cfg_oqpsk, .cfg_pre_bits, .in_valid, .in_data,
    .in_ready, .chip_out, .chip_valid
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  bit frame_on = 0;
  bit start_req = 0;
  bit en_every = 0;
  bit exp_q[$];
  byte unsigned tx[$];
  logic [31:0] cap;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_chip(input int g, input int k);
    int len, bw, r, top, step, src;
    bit c;
    len  = cfg_len16 ? 16 : 8;
    bw   = cfg_bits4 ? 4 : 2;
    r    = g % (1 << (bw - 1));
    top  = g / (1 << (bw - 1));
    step = len / (1 << (bw - 1));
    src  = (k + r * step) % len;
    c    = cfg_base[src];
    if (top != 0) begin
      if (!cfg_oqpsk) c = !c;
      else if (k % 2 == 0) c = !c;
    end
    return c;
  endfunction

  task automatic push_group(input int g);
    int len;
    len = cfg_len16 ? 16 : 8;
    for (int k = 0; k < len; k++) exp_q.push_back(ref_chip(g, k));
  endtask

  task automatic push_byte(input int b);
    int bw, ng, pos;
    bw = cfg_bits4 ? 4 : 2;
    ng = 8 / bw;
    for (int j = 0; j < ng; j++) begin
      pos = cfg_msb_first ? (ng - 1 - j) : j;
      push_group((b >> (pos * bw)) % (1 << bw));
    end
  endtask

  task automatic step(input string tag);
    bit exp_valid, exp_ready, popped;
    @(negedge clk);
    chip_en  = en_every ? 1'b1 : ($urandom_range(0, 2) != 0);
    start    = start_req;
    in_valid = tx.size() > 0;
    in_data  = (tx.size() > 0) ? tx[0] : 8'h00;
    #1;
    exp_valid = exp_q.size() > 0;
    exp_ready = frame_on && (exp_q.size() == 0 || (chip_en && exp_q.size() == 1));
    chk(chip_valid == exp_valid, tag, "chip_valid (R5)", int'(chip_valid), int'(exp_valid));
    chk(in_ready == exp_ready, tag, "in_ready (R8)", int'(in_ready), int'(exp_ready));
    if (exp_valid)
      chk(chip_out == exp_q[0], tag, "chip_out", int'(chip_out), int'(exp_q[0]));
    popped = 0;
    if (chip_en && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      cap = {chip_out, cap[31:1]};
      popped = 1;
    end
    if (start && !frame_on) begin
      frame_on = 1;
      for (int p = 0; p < int'(cfg_pre_bits) / (cfg_bits4 ? 4 : 2); p++) push_group(0);
    end else if (in_valid && exp_ready) begin
      push_byte(int'(in_data));
      void'(tx.pop_front());
    end else if (popped && exp_q.size() == 0) begin
      frame_on = 0;
    end
  endtask

  task automatic send_frame(input string tag, input int restart_at);
    int n;
    cap = '0;
    start_req = 1;
    step(tag);
    start_req = 0;
    n = 0;
    while (frame_on || tx.size() > 0) begin
      start_req = (n == restart_at);
      step(tag);
      start_req = 0;
      n++;
      if (n > 20000) begin
        fails++;
        $display("FAIL %s frame did not finish actual=%0d expected=%0d", tag, n, 0);
        tx.delete();
        exp_q.delete();
        frame_on = 0;
        break;
      end
    end
    step(tag);
    chk(!chip_valid && !in_ready, tag, "closed after frame (R9)",
        int'({chip_valid, in_ready}), 0);
  endtask

  task automatic load_demo_payload();
    byte unsigned pl[16] = '{8'h0F, 8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD,
                             8'hEF, 8'h00, 8'h00, 8'h55, 8'h55, 8'hAA, 8'hAA, 8'hFF};
    foreach (pl[i]) tx.push_back(pl[i]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(chip_valid == 1'b0, "R11", "chip_valid in reset", int'(chip_valid), 0);
    chk(in_ready == 1'b0, "R11", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    step("R11");
    chk(chip_valid == 1'b0 && in_ready == 1'b0, "R11", "quiet after reset",
        int'({chip_valid, in_ready}), 0);

    // R1 R2 R7: 8-chip codes, 2-bit groups, 20 preamble copies
    cfg_base = 16'h00B2; cfg_len16 = 0; cfg_bits4 = 0; cfg_msb_first = 0;
    cfg_oqpsk = 0; cfg_pre_bits = 8'd40; en_every = 0;
    load_demo_payload();
    send_frame("R1 R2 R7", -1);

    // R6: high group first
    cfg_msb_first = 1;
    load_demo_payload();
    send_frame("R6", -1);

    // R1 R2: 16-chip codes, 4-bit groups
    cfg_base = 16'h926F; cfg_len16 = 1; cfg_bits4 = 1; cfg_msb_first = 0;
    cfg_pre_bits = 8'd32;
    load_demo_payload();
    send_frame("R1 R2", -1);

    // R3: conjugation with enables on every cycle
    cfg_base = 16'h7AC9; cfg_oqpsk = 1; cfg_msb_first = 1; en_every = 1;
    load_demo_payload();
    send_frame("R3", -1);

    // R1: the other two length/group pairings; R7 floor of preamble count
    cfg_base = 16'hC35A; cfg_oqpsk = 0; cfg_len16 = 1; cfg_bits4 = 0;
    cfg_pre_bits = 8'd5; en_every = 0;
    tx.push_back(8'h1B); tx.push_back(8'hE4); tx.push_back(8'h96);
    send_frame("R1 R7", -1);
    cfg_base = 16'h006D; cfg_len16 = 0; cfg_bits4 = 1; cfg_pre_bits = 8'd6;
    cfg_oqpsk = 1;
    tx.push_back(8'h7F); tx.push_back(8'h80); tx.push_back(8'h3C);
    send_frame("R1 R3", -1);

    // R4: fixed example, no preamble, low group first
    cfg_base = 16'h00B2; cfg_len16 = 0; cfg_bits4 = 0; cfg_oqpsk = 0;
    cfg_msb_first = 0; cfg_pre_bits = 8'd0; en_every = 1;
    tx.push_back(8'hE4);
    send_frame("R4", -1);
    chk(cap == 32'hD44D2BB2, "R4", "example chip word", int'(cap), int'(32'hD44D2BB2));

    // R6: same byte, high group first
    cfg_msb_first = 1;
    tx.push_back(8'hE4);
    send_frame("R6", -1);
    chk(cap == 32'hB22B4DD4, "R6", "reversed group word", int'(cap), int'(32'hB22B4DD4));

    // R10: start pulse in the middle of an open frame
    cfg_msb_first = 0; cfg_pre_bits = 8'd8; en_every = 0;
    tx.push_back(8'h5A); tx.push_back(8'hC3); tx.push_back(8'h0F);
    send_frame("R10", 30);
    tx.push_back(8'h99);
    send_frame("R10 R9", 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule